// File: doc/BRIEF.md
# Serial Packet Transmitter with CRC-5, Bit Stuffing and NRZI

This block turns one fixed 32-bit packet into a differential line signal. On an accepted start it captures a 3-bit packet number, a 4-bit target address and a 16-bit payload word. Before any bit leaves, it computes a 5-bit check code over those 23 bits. The packet is then shifted out one bit per bit time, where a bit time is any clock edge with `bit_en_i` high. On the way out the bits pass through a run-length limiter (bit stuffing) and an NRZI line coder, which drives the two line outputs.

The payload word can carry plain data, a function code or an acknowledge. Two fixed token values are used by convention: 0x0009 requests a read and 0x000D requests a write. Both are transmitted like any other payload.

After the last bit the block signals end of packet and releases the line. It then holds `busy_o` through an idle gap before it accepts the next start, so back-to-back requests cannot violate the minimum spacing between packets.

Top module: `usb_pkt_tx`

## Requirements
- R1: After reset the block is quiet: `busy_o`=0, `done_o`=0, `oe_o`=0, and the line is in the idle J level (`dp_o`=1, `dm_o`=0).
- R2: The logical bit order on the wire is fixed:
  - four sync bits 0,0,0,1 in time order;
  - then the packet number, the address and the payload word, each least significant bit first.
- R3: The last five bits are a check code, computed as follows:
  - the register is preset to 11111 and uses the generator x^5+x^2+1;
  - it is fed the 23 number/address/payload bits in wire order;
  - the result is complemented and sent highest register bit first.
- R4: NRZI coding: a logical 0 flips the line and a logical 1 holds it. The first sync bit is coded relative to the idle J level, and `dm_o` is always the inverse of `dp_o` during data.
- R5: After six consecutive logical 1s an extra 0 is inserted. This applies everywhere, including the sync bits, the check code and after the final check bit. An inserted bit restarts the run count.
- R6: End of packet is shown in three steps:
  - two bit times with both lines low and `oe_o`=1;
  - then one bit time of J with `oe_o`=1;
  - then `oe_o` falls.
- R7: `done_o` is high for exactly one clock, on the edge at which `oe_o` falls after end of packet.
- R8: `busy_o` rises only on the clock edge after an accepted start, stays high through the packet and two further bit times after the line is released, and then falls. `oe_o` is never high while `busy_o` is low.
- R9: A start request while `busy_o` is high is ignored, including one that lands on the cycle of `done_o`. The packet in flight is unchanged and no further packet follows it.
- R10: The outputs change only on clock edges where `bit_en_i` is high. When `bit_en_i` is held low, the line state freezes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| pkt_num_i | input | 3 | Packet number field |
| addr_i | input | 4 | Target address field |
| field_i | input | 16 | Payload word (data, function, acknowledge or token code) |
| bit_en_i | input | 1 | One-cycle strobe marking a bit time |
| busy_o | output | 1 | Packet in progress or inter-packet gap pending |
| done_o | output | 1 | One-clock pulse when the line is released |
| dp_o | output | 1 | Positive data line |
| dm_o | output | 1 | Negative data line |
| oe_o | output | 1 | Line driver enable |

## Verification
The collision of interest is a start request that arrives on the very edge where `done_o` pulses. At that edge the line has just been released, but the inter-packet gap is still running. The bench raises `start_i` at the falling edge where it sees `done_o` high, with the bit strobe at full rate so the gap lasts as little as possible. It judges the outcome in two ways: the scoreboard must consume exactly the expected entries of the original packet, and `busy_o` and `oe_o` must be low a few bit times later, which shows that no second packet started.

// File: rtl/usb_pkt_pkg.sv
package usb_pkt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_DATA,
    ST_SE0,
    ST_J,
    ST_GAP
  } tx_state_e;

  // sync pattern, bit 0 leaves first: 0,0,0,1
  localparam logic [3:0] SYNC_SEQ  = 4'b1000;
  localparam logic [4:0] CRC5_POLY = 5'b00101;

endpackage

// File: rtl/pkt_crc5.sv
module pkt_crc5 #(
  parameter int          DATA_W = 23,
  parameter int          CRC_W  = 5,
  parameter logic [CRC_W-1:0] POLY = 5'b00101
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);

  logic [CRC_W-1:0] chain [DATA_W+1];

  assign chain[0] = '1;

  for (genvar i = 0; i < DATA_W; i++) begin : g_stage
    logic fb;
    assign fb = chain[i][CRC_W-1] ^ data_i[i];
    assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_o = chain[DATA_W];

endmodule

// File: rtl/pkt_framer.sv
module pkt_framer import usb_pkt_pkg::*; #(
  parameter int NUM_W   = 3,
  parameter int ADDR_W  = 4,
  parameter int FIELD_W = 16,
  parameter int CRC_W   = 5,
  localparam int SYNC_W = 4,
  localparam int BODY_W = NUM_W + ADDR_W + FIELD_W,
  localparam int PKT_W  = SYNC_W + BODY_W + CRC_W
) (
  input  logic [NUM_W-1:0]   num_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic [PKT_W-1:0]   frame_o
);

  logic [BODY_W-1:0] body;
  logic [CRC_W-1:0]  crc;
  logic [CRC_W-1:0]  crc_tx;

  assign body = {field_i, addr_i, num_i};

  pkt_crc5 #(
    .DATA_W (BODY_W),
    .CRC_W  (CRC_W),
    .POLY   (CRC5_POLY)
  ) u_crc (
    .data_i (body),
    .crc_o  (crc)
  );

  // complemented, top register bit leaves first
  for (genvar i = 0; i < CRC_W; i++) begin : g_crc_rev
    assign crc_tx[i] = ~crc[CRC_W-1-i];
  end

  assign frame_o = {crc_tx, body, SYNC_SEQ};

endmodule

// File: rtl/pkt_nrzi_stuff.sv
module pkt_nrzi_stuff #(
  parameter int  RUN_MAX = 6,
  localparam int RUN_W   = $clog2(RUN_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  input  logic bit_i,
  output logic stuff_o,
  output logic line_o
);

  logic             line_q;
  logic [RUN_W-1:0] run_q;

  assign stuff_o = (run_q == RUN_W'(RUN_MAX));
  assign line_o  = line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b1;
      run_q  <= '0;
    end else if (clear_i) begin
      line_q <= 1'b1;
      run_q  <= '0;
    end else if (step_i) begin
      if (stuff_o || !bit_i) begin
        line_q <= ~line_q;
        run_q  <= '0;
      end else begin
        run_q  <= run_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/usb_pkt_tx.sv
module usb_pkt_tx import usb_pkt_pkg::*; #(
  parameter int NUM_W     = 3,
  parameter int ADDR_W    = 4,
  parameter int FIELD_W   = 16,
  parameter int CRC_W     = 5,
  parameter int STUFF_RUN = 6,
  parameter int EOP_SE0   = 2,
  parameter int GAP_BITS  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [NUM_W-1:0]   pkt_num_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic               bit_en_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               dp_o,
  output logic               dm_o,
  output logic               oe_o
);

  localparam int PKT_W    = 4 + NUM_W + ADDR_W + FIELD_W + CRC_W;
  localparam int CNT_W    = $clog2(PKT_W + 1);
  localparam int TICK_MAX = (EOP_SE0 > GAP_BITS) ? EOP_SE0 : GAP_BITS;
  localparam int TICK_W   = $clog2(TICK_MAX + 1);

  tx_state_e          state_q, state_d;
  logic [PKT_W-1:0]   frame, shreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [TICK_W-1:0]  tick_q;
  logic               done_q;
  logic               sending, stuff, line, frame_end, enc_step;

  pkt_framer #(
    .NUM_W   (NUM_W),
    .ADDR_W  (ADDR_W),
    .FIELD_W (FIELD_W),
    .CRC_W   (CRC_W)
  ) u_framer (
    .num_i   (pkt_num_i),
    .addr_i  (addr_i),
    .field_i (field_i),
    .frame_o (frame)
  );

  assign sending   = (state_q == ST_ARM) || (state_q == ST_DATA);
  assign frame_end = (cnt_q == CNT_W'(PKT_W)) && !stuff;
  assign enc_step  = sending && bit_en_i && !frame_end;

  pkt_nrzi_stuff #(
    .RUN_MAX (STUFF_RUN)
  ) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (state_q == ST_IDLE),
    .step_i  (enc_step),
    .bit_i   (shreg_q[0]),
    .stuff_o (stuff),
    .line_o  (line)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ARM;
      ST_ARM,
      ST_DATA: if (bit_en_i) state_d = frame_end ? ST_SE0 : ST_DATA;
      ST_SE0:  if (bit_en_i && tick_q == TICK_W'(EOP_SE0 - 1)) state_d = ST_J;
      ST_J:    if (bit_en_i) state_d = ST_GAP;
      ST_GAP:  if (bit_en_i && tick_q == TICK_W'(GAP_BITS - 1)) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      tick_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_J) && bit_en_i;
      if (state_q == ST_IDLE && start_i) begin
        shreg_q <= frame;
        cnt_q   <= '0;
      end else if (enc_step && !stuff) begin
        shreg_q <= shreg_q >> 1;
        cnt_q   <= cnt_q + 1'b1;
      end
      if (state_d != state_q) begin
        tick_q <= '0;
      end else if (bit_en_i && (state_q == ST_SE0 || state_q == ST_GAP)) begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_DATA: begin oe_o = 1'b1; dp_o = line; dm_o = ~line; end
      ST_SE0:  begin oe_o = 1'b1; dp_o = 1'b0; dm_o = 1'b0;  end
      ST_J:    begin oe_o = 1'b1; dp_o = 1'b1; dm_o = 1'b0;  end
      default: begin oe_o = 1'b0; dp_o = 1'b1; dm_o = 1'b0;  end
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

endmodule

// File: rtl/pkt_tx_checker.sv
module pkt_tx_checker #(
  parameter int  RUN_MAX = 6,
  localparam int RUN_W   = $clog2(RUN_MAX + 2)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic bit_en_i,
  input logic busy_o,
  input logic done_o,
  input logic dp_o,
  input logic dm_o,
  input logic oe_o
);

  logic             step_d, last_dp, last_valid;
  logic [RUN_W-1:0] run_q;

  // counts data bit times in which the line held its level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_d     <= 1'b0;
      last_dp    <= 1'b1;
      last_valid <= 1'b0;
      run_q      <= '0;
    end else begin
      step_d <= bit_en_i;
      if (step_d) begin
        if (oe_o && (dp_o != dm_o)) begin
          run_q      <= (last_valid && dp_o == last_dp) ? run_q + 1'b1 : '0;
          last_dp    <= dp_o;
          last_valid <= 1'b1;
        end else begin
          run_q      <= '0;
          last_valid <= 1'b0;
        end
      end
    end
  end

  assert_stuff_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_W'(RUN_MAX));

  assert_no_se1_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dp_o && dm_o));

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!oe_o && $past(oe_o)));

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !oe_o);

  assert_busy_from_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_hold_no_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bit_en_i) |-> $stable({dp_o, dm_o, oe_o}));

endmodule

bind usb_pkt_tx pkt_tx_checker #(.RUN_MAX(STUFF_RUN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .bit_en_i (bit_en_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .dp_o     (dp_o),
  .dm_o     (dm_o),
  .oe_o     (oe_o)
);

// File: tb/usb_pkt_tx_tb.sv
module usb_pkt_tx_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  pkt_num_i = '0;
  logic [3:0]  addr_i = '0;
  logic [15:0] field_i = '0;
  logic        bit_en_i = 1'b0;
  logic        busy_o, done_o, dp_o, dm_o, oe_o;

  int n_checks = 0;
  int n_fail   = 0;

  // expected per bit time: {oe, dp, dm, done, busy}
  logic [4:0] exp_q[$];
  string      tag_q[$];

  int   en_period = 3;
  int   en_cnt = 0;
  logic en_hold = 1'b0;
  logic mon_on = 1'b0;
  logic en_prev = 1'b0;
  logic busy_prev = 1'b0;
  logic [2:0] last_obs = 3'b010;

  usb_pkt_tx u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .pkt_num_i (pkt_num_i),
    .addr_i    (addr_i),
    .field_i   (field_i),
    .bit_en_i  (bit_en_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .dp_o      (dp_o),
    .dm_o      (dm_o),
    .oe_o      (oe_o)
  );

  always #2.5 clk_i = ~clk_i;

  // bit-time strobe, changed just after the rising edge
  always @(posedge clk_i) begin
    #1;
    if (en_hold) begin
      bit_en_i = 1'b0;
    end else if (en_cnt + 1 >= en_period) begin
      en_cnt   = 0;
      bit_en_i = 1'b1;
    end else begin
      en_cnt   = en_cnt + 1;
      bit_en_i = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [4:0] act, input logic [4:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [4:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // reference model built from the requirements
  task automatic expect_pkt(input logic [2:0] n, input logic [3:0] a, input logic [15:0] f);
    logic [31:0] bits;
    logic [4:0]  c;
    logic        line, fb;
    int          run;
    bits[3:0]   = 4'b1000;
    bits[6:4]   = n;
    bits[10:7]  = a;
    bits[26:11] = f;
    c = 5'b11111;
    for (int i = 4; i < 27; i++) begin
      fb = c[4] ^ bits[i];
      c  = {c[3:0], 1'b0};
      if (fb) c = c ^ 5'b00101;
    end
    for (int i = 0; i < 5; i++) bits[27+i] = ~c[4-i];
    line = 1'b1;
    run  = 0;
    for (int i = 0; i < 32; i++) begin
      if (bits[i]) run++;
      else begin line = ~line; run = 0; end
      push({1'b1, line, ~line, 1'b0, 1'b1},
           (i < 4) ? "R4 sync" : ((i < 27) ? "R2 body" : "R3 crc"));
      if (run == 6) begin
        line = ~line;
        run  = 0;
        push({1'b1, line, ~line, 1'b0, 1'b1}, "R5 stuff");
      end
    end
    push(5'b10001, "R6 se0");
    push(5'b10001, "R6 se0");
    push(5'b11001, "R6 J");
    push(5'b01011, "R7 release");
    push(5'b01001, "R8 gap");
    push(5'b01000, "R8 gap end");
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (mon_on) begin
      if (en_prev && busy_prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected bit time", {oe_o, dp_o, dm_o, done_o, busy_o}, 5'b01000);
        end else begin
          logic [4:0] e;
          string      t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({oe_o, dp_o, dm_o, done_o, busy_o} === e, t, "line",
                {oe_o, dp_o, dm_o, done_o, busy_o}, e);
        end
      end else if (!en_prev && busy_prev) begin
        check({oe_o, dp_o, dm_o} === last_obs && !done_o, "R10", "hold",
              {oe_o, dp_o, dm_o, done_o, busy_o}, {last_obs, 1'b0, busy_o});
      end
    end
    en_prev   = bit_en_i;
    busy_prev = busy_o;
    last_obs  = {oe_o, dp_o, dm_o};
  end

  task automatic wait_idle();
    while (busy_o || exp_q.size() != 0) @(negedge clk_i);
  endtask

  task automatic send(input logic [2:0] n, input logic [3:0] a, input logic [15:0] f);
    wait_idle();
    @(negedge clk_i);
    expect_pkt(n, a, f);
    pkt_num_i = n;
    addr_i    = a;
    field_i   = f;
    start_i   = 1'b1;
    @(negedge clk_i);
    start_i   = 1'b0;
  endtask

  task automatic poke_start(input logic [15:0] f);
    @(negedge clk_i);
    field_i   = f;
    pkt_num_i = ~pkt_num_i;
    start_i   = 1'b1;
    @(negedge clk_i);
    start_i   = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk_i);
    // R1 reset state
    check({oe_o, dp_o, dm_o, done_o, busy_o} === 5'b01000, "R1", "reset",
          {oe_o, dp_o, dm_o, done_o, busy_o}, 5'b01000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check({oe_o, dp_o, dm_o, done_o, busy_o} === 5'b01000, "R1", "after reset",
          {oe_o, dp_o, dm_o, done_o, busy_o}, 5'b01000);
    mon_on = 1'b1;

    en_period = 3;
    send(3'd5, 4'hA, 16'h0009);   // read-request token
    send(3'd2, 4'h3, 16'h000D);   // write-request token

    en_period = 1;
    send(3'd7, 4'hF, 16'hFFFF);   // R5 long runs of ones
    send(3'd0, 4'h0, 16'h0000);

    // R9 start while busy, mid-packet
    en_period = 4;
    send(3'd1, 4'h6, 16'hA5C3);
    repeat (30) @(negedge clk_i);
    poke_start(16'h1234);
    // R10 strobe held low mid-packet
    en_hold = 1'b1;
    repeat (20) @(negedge clk_i);
    en_hold = 1'b0;
    wait_idle();
    repeat (12) @(negedge clk_i);
    check(!busy_o && !oe_o, "R9", "no extra packet",
          {oe_o, dp_o, dm_o, done_o, busy_o}, 5'b01000);

    // R9 start on the done cycle, strobe at full rate
    en_period = 1;
    send(3'd6, 4'h9, 16'h7E81);
    while (!done_o) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_idle();
    repeat (6) @(negedge clk_i);
    check(!busy_o && !oe_o, "R9", "start at done ignored",
          {oe_o, dp_o, dm_o, done_o, busy_o}, 5'b01000);

    en_period = 2;
    send(3'd3, 4'h5, 16'h3F7F);
    wait_idle();
    repeat (4) @(negedge clk_i);
    finish_run();
  end

endmodule